// File: doc/BRIEF.md
# Row-Stationary 2-D Convolution Array

This block computes a single-channel two-dimensional convolution (correlation form) of an R×R filter over an H-row by W-column feature map. It is a grid of processing elements with R rows and H−R+1 columns. Each element keeps one filter row and a sliding window of R elements from one feature-map row, and it evaluates one 1-D dot product per window position. A filter row is given to every element of one grid row. Feature-map row r goes to every element on the diagonal where grid row plus grid column equals r. Partial sums run down each grid column from a zero start at the top, so the bottom of column j holds output row j.

Filter rows are written one at a time through a select and write-enable. The feature map then arrives column by column: each accepted beat carries one element of every feature-map row. After the R-th beat of a row pass, every accepted beat yields one registered output column, which holds one element of every output row, together with a one-cycle valid pulse. A pass ends after W beats and the next beat begins a new pass. Partial sums are never held outside the array.

Top module: `rs_conv_array`

## Requirements
- R1: While reset (synchronous, active low) is asserted and on the first cycle after it, out_valid is 0 and out_data is all zeros.
- R2: A write with flt_we=1 and flt_sel=i loads flt_data into filter row i of every element in grid row i. Tap k is taken from bits [k*DW +: DW] and pairs with the window element k positions after the oldest. Filter rows that are not selected keep their contents.
- R3: out_valid is 1 in the cycle after an accepted beat (fm_valid=1) whose position x within the current pass satisfies x ≥ R−1. It is 0 otherwise, so a pass of W beats gives exactly W−R+1 pulses.
- R4: When out_valid follows the beat at position x, out_data field j (bits [j*AW +: AW], two's complement) equals the sum over i,k in 0..R−1 of F[i][k]·I[j+i][x−R+1+k]. Here I[r] is the feature-map row carried in fm_data bits [r*DW +: DW].
- R5: A cycle with fm_valid=0 changes no window and no pass position. The following cycle has out_valid=0 and out_data unchanged.
- R6: The position wraps to 0 after W accepted beats. The first R−1 beats of the next pass produce no valid output, and their results depend only on that pass's data.
- R7: Data and filters are signed DW-bit values. AW is wide enough that the full-scale sums (for example ±128·±128 over R² taps with DW=8) are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_we | input | 1 | Filter row write strobe |
| flt_sel | input | $clog2(R) | Filter row index to write |
| flt_data | input | R*DW | Filter row taps, tap k at [k*DW +: DW] |
| fm_valid | input | 1 | Feature-map beat valid |
| fm_data | input | H*DW | One element of each feature-map row, row r at [r*DW +: DW] |
| out_valid | output | 1 | Output column valid pulse |
| out_data | output | (H-R+1)*AW | One element of each output row, row j at [j*AW +: AW] |

## Verification
The assertions assume that the feature map arrives in whole passes of W beats, so the checker's own beat counter stays aligned with the pass position. They also assume that filter writes do not fall inside a pass whose results are checked. The bench always sends complete passes, with idle gaps of varying length between beats, and writes filter rows only between passes. The expected result for every output column is computed arithmetically from the bench's own copy of the filter and image. The patterns are a ramp, a scrambled full-range set, and both signed extremes.

// File: rtl/rs_conv_array.sv
module rs_conv_array #(
  parameter int DW = 8,
  parameter int R  = 3,
  parameter int W  = 8,
  parameter int H  = 6,
  localparam int NCOL = H - R + 1,
  localparam int SW   = $clog2(R),
  localparam int CW   = $clog2(W),
  localparam int AW   = 2*DW + $clog2(R*R) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flt_we,
  input  logic [SW-1:0]        flt_sel,
  input  logic [R*DW-1:0]      flt_data,
  input  logic                 fm_valid,
  input  logic [H*DW-1:0]      fm_data,
  output logic                 out_valid,
  output logic [NCOL*AW-1:0]   out_data
);

  logic [CW-1:0] pos_q;
  logic          emit;
  logic signed [AW-1:0] ps [R+1][NCOL];

  assign emit = fm_valid && (pos_q >= CW'(R-1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= '0;
    else if (fm_valid)
      pos_q <= (pos_q == CW'(W-1)) ? '0 : pos_q + 1'b1;
  end

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    assign ps[0][j] = '0;
    for (genvar i = 0; i < R; i++) begin : g_pe
      logic signed [DW-1:0] f_q [R];
      logic signed [DW-1:0] w_q [R];
      logic signed [DW-1:0] w_nx [R];
      logic signed [AW-1:0] dot;

      for (genvar k = 0; k < R; k++) begin : g_tap
        if (k < R-1) begin : g_old
          assign w_nx[k] = w_q[k+1];
        end else begin : g_new
          assign w_nx[k] = fm_data[(i+j)*DW +: DW];
        end

        always_ff @(posedge clk) begin
          if (!rst_n) begin
            f_q[k] <= '0;
            w_q[k] <= '0;
          end else begin
            if (flt_we && flt_sel == SW'(i))
              f_q[k] <= flt_data[k*DW +: DW];
            if (fm_valid)
              w_q[k] <= w_nx[k];
          end
        end
      end

      always_comb begin
        dot = '0;
        for (int k = 0; k < R; k++)
          dot = dot + AW'(f_q[k]) * AW'(w_nx[k]);
      end

      assign ps[i+1][j] = ps[i][j] + dot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit)
        for (int j = 0; j < NCOL; j++)
          out_data[j*AW +: AW] <= ps[R][j];
    end
  end

endmodule

// File: rtl/rs_conv_array_chk.sv
module rs_conv_array_chk #(
  parameter int R    = 3,
  parameter int W    = 8,
  parameter int NCOL = 4,
  parameter int AW   = 21,
  localparam int CW  = $clog2(W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fm_valid,
  input logic               out_valid,
  input logic [NCOL*AW-1:0] out_data
);

  logic [CW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      beat_q <= '0;
    else if (fm_valid)
      beat_q <= (beat_q == CW'(W-1)) ? '0 : beat_q + 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && out_data == '0);

  a_r3_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fm_valid) && $past(beat_q) >= CW'(R-1));

  a_r3_full_window_emits: assert property (@(posedge clk) disable iff (!rst_n)
    fm_valid && beat_q >= CW'(R-1) |=> out_valid);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fm_valid |=> !out_valid && $stable(out_data));

  a_r6_pass_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fm_valid && beat_q < CW'(R-1) |=> !out_valid);

endmodule

bind rs_conv_array rs_conv_array_chk #(.R(R), .W(W), .NCOL(NCOL), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fm_valid(fm_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/rs_conv_array_tb_top.sv
`timescale 1ns/1ps
module rs_conv_array_tb_top;
  localparam int DW = 8, R = 3, W = 8, H = 6;
  localparam int NCOL = H - R + 1;
  localparam int SW = $clog2(R);
  localparam int AW = 2*DW + $clog2(R*R) + 1;

  logic clk = 0, rst_n = 0, flt_we = 0, fm_valid = 0;
  logic [SW-1:0] flt_sel = '0;
  logic [R*DW-1:0] flt_data = '0;
  logic [H*DW-1:0] fm_data = '0;
  logic out_valid;
  logic [NCOL*AW-1:0] out_data;

  int n_chk = 0, n_bad = 0;
  int flt [R][R];
  int img [H][W];
  bit done = 0;

  always #2.5 clk = ~clk;

  rs_conv_array #(.DW(DW), .R(R), .W(W), .H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_sel(flt_sel),
    .flt_data(flt_data), .fm_valid(fm_valid), .fm_data(fm_data),
    .out_valid(out_valid), .out_data(out_data));

  function automatic int col_out(int j);
    logic signed [AW-1:0] v;
    v = out_data[j*AW +: AW];
    return int'(v);
  endfunction

  function automatic int golden(int j, int x0);
    int s = 0;
    for (int i = 0; i < R; i++)
      for (int k = 0; k < R; k++)
        s += flt[i][k] * img[j+i][x0+k];
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_row(int i);
    @(negedge clk);
    flt_we = 1; flt_sel = SW'(i);
    for (int k = 0; k < R; k++) flt_data[k*DW +: DW] = DW'(flt[i][k]);
    @(negedge clk);
    flt_we = 0;
  endtask

  // gap: idle cycles inserted after beats when (x % 3) < gap
  task automatic run_pass(int gap, string tag);
    int last [NCOL];
    for (int x = 0; x < W; x++) begin
      @(negedge clk);
      fm_valid = 1;
      for (int r = 0; r < H; r++) fm_data[r*DW +: DW] = DW'(img[r][x]);
      @(posedge clk); #1;
      fm_valid = 0;
      if (x >= R-1) begin
        check(out_valid === 1'b1, "R3 valid after full window", int'(out_valid), 1);
        for (int j = 0; j < NCOL; j++) begin
          last[j] = col_out(j);
          check(last[j] == golden(j, x-R+1), {"R4 ", tag}, last[j], golden(j, x-R+1));
        end
      end else begin
        check(out_valid === 1'b0, "R6 no valid in first R-1 beats", int'(out_valid), 0);
      end
      if ((x % 3) < gap) begin
        @(posedge clk); #1;
        check(out_valid === 1'b0, "R5 idle gives no valid", int'(out_valid), 0);
        if (x >= R-1)
          for (int j = 0; j < NCOL; j++)
            check(col_out(j) == last[j], "R5 idle holds data", col_out(j), last[j]);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R1 valid low in reset", int'(out_valid), 0);
    check(out_data == '0, "R1 data zero in reset", 0, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R1 valid low after reset", int'(out_valid), 0);

    // ramp image, small filter
    for (int i = 0; i < R; i++)
      for (int k = 0; k < R; k++) flt[i][k] = i*R + k - 4;
    for (int i = 0; i < R; i++) load_row(i);
    for (int r = 0; r < H; r++)
      for (int x = 0; x < W; x++) img[r][x] = r*W + x - 20;
    run_pass(0, "ramp");
    run_pass(2, "ramp with gaps R6");

    // R2: rewrite only filter row 1
    for (int k = 0; k < R; k++) flt[1][k] = 17 - 9*k;
    load_row(1);
    run_pass(1, "R2 row 1 reloaded");

    // scrambled full-range image and filter, several seeds
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < R; i++)
        for (int k = 0; k < R; k++) flt[i][k] = ((i*53 + k*29 + s*71) % 256) - 128;
      for (int i = 0; i < R; i++) load_row(i);
      for (int r = 0; r < H; r++)
        for (int x = 0; x < W; x++) img[r][x] = ((r*37 + x*91 + s*13 + r*x*7) % 256) - 128;
      run_pass(s % 3, "scrambled R7");
    end

    // signed extremes R7
    for (int i = 0; i < R; i++)
      for (int k = 0; k < R; k++) flt[i][k] = -128;
    for (int i = 0; i < R; i++) load_row(i);
    for (int r = 0; r < H; r++)
      for (int x = 0; x < W; x++) img[r][x] = -128;
    run_pass(0, "R7 max positive");
    for (int i = 0; i < R; i++)
      for (int k = 0; k < R; k++) flt[i][k] = 127;
    for (int i = 0; i < R; i++) load_row(i);
    run_pass(0, "R7 max negative");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule